// File: doc/BRIEF.md
# Flash Block Lock and Status Sequencer

This block is the command front end of a block-organised flash array. The array itself is held in on-chip registers, one byte per cell. Software sends one-cycle commands. The commands cover:

- programming a byte
- erasing one block, or every block that is not protected
- protecting a block
- querying a block's protection
- reading status, clearing status, and returning to normal reads

Each block has one stored protection bit. The bit is active low: a 0 means the block is protected. Only the protect command can clear the bit, and only an erase of that block can set it again. A global bypass input makes every block writable without changing the stored bits.

Long operations hold the block busy for a fixed, parameterised number of cycles. During that time every new command is ignored. A status byte reports ready, erase failure and program failure. That byte is also returned through the array read port while the port is in status mode. Three output pins mirror the ready and failure flags.

Top module: `flash_lock_seq`

## Requirements
- R1: After reset every array byte reads 0xFF, every block's protection bit is 1 (unprotected), ready is 1, both failure flags are 0 and the read port is in array mode.
- R2: A command is taken on a rising edge where `cmd_valid` is 1 and `ready` is 1. The `cmd_op` codes are: 0 = read array, 1 = read status, 2 = clear status, 3 = program, 4 = erase block, 5 = erase all unprotected, 6 = protect block, 7 = read protection. A command presented while `ready` is 0 has no effect.
- R3: Codes 3 to 7 drive `ready` to 0 for exactly BUSY_CYCLES cycles after the accepting edge. Their effect on the array, the protection bits and the flags lands on the edge where `ready` returns to 1. Codes 0 to 2 take effect on the accepting edge and never drop `ready`.
- R4: Program stores the bitwise AND of `cmd_data` and the addressed byte. It can only turn bits from 1 to 0.
- R5: A completed erase sets every byte of the erased block to 0xFF and that block's protection bit to 1. Erase-all erases every block that is effectively unprotected.
- R6: Protect block clears the target block's protection bit to 0, whatever the bypass input is. No command sets a protection bit.
- R7: Suppose `lock_bypass` is 0 and the target block's protection bit is 0. Then program leaves the array unchanged and sets status bit 4, and erase block leaves it unchanged and sets status bit 5. Erase-all skips that block without setting a flag.
- R8: While `lock_bypass` is 1, program and erase succeed on every block, and the stored protection bits are kept. When `lock_bypass` returns to 0, the kept bits are enforced again. `lock_bypass` is sampled on the completion edge.
- R9: The status byte is {ready, 0, erase_fail, program_fail, 0000} (bit 7, 6, 5, 4, 3..0). In status mode, a read at an even address returns the status byte and a read at an odd address returns array data. Read status and codes 3 to 6 put the port in status mode.
- R10: Read protection puts the port in protection mode. Once the command completes, every read returns 0x40 if the target block's bit is 1 and 0x00 if it is 0.
- R11: The failure flags stay set until clear status. Clear status clears both flags and leaves the read mode unchanged. `prog_fail` and `erase_fail` mirror status bits 4 and 5, and `ready` mirrors bit 7.
- R12: Read array returns the port to array mode, where every address returns array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | AW (6) | Byte address; the upper bits select the block |
| cmd_data | input | 8 | Program data |
| lock_bypass | input | 1 | 1 = treat all blocks as unprotected |
| rd_addr | input | AW (6) | Read port address |
| rd_data | output | 8 | Read port data, combinational from `rd_addr` and the mode |
| ready | output | 1 | Sequencer idle (status bit 7) |
| erase_fail | output | 1 | Erase failure flag (status bit 5) |
| prog_fail | output | 1 | Program failure flag (status bit 4) |

## Verification
Codes 0 to 2 act on the accepting edge, so their mode or flag change is visible from the next cycle's read. Codes 3 to 7 show `ready` at 0 in the cycle after acceptance, and their array, protection and flag changes appear in the cycle that starts after the BUSY_CYCLES-th following edge. The bench's reference model steps on the same rising edges and counts the same busy window. It compares `ready`, the flags and `rd_data` in the middle of every cycle, where both sides have settled. Directed reads with fixed expected values are always taken after that window has closed.

// File: rtl/fls_pkg.sv
// Shared command codes, read-port modes and status bit positions for the
// flash lock/status sequencer. Assumes a 3-bit command field.
package fls_pkg;
    typedef enum logic [2:0] {
        OP_RD_ARRAY  = 3'd0,
        OP_RD_STATUS = 3'd1,
        OP_CLR_STAT  = 3'd2,
        OP_PROGRAM   = 3'd3,
        OP_ERASE_BLK = 3'd4,
        OP_ERASE_ALL = 3'd5,
        OP_PROTECT   = 3'd6,
        OP_RD_PROT   = 3'd7
    } fls_op_e;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_STATUS = 2'd1,
        MODE_PROT   = 2'd2
    } fls_mode_e;

    localparam int unsigned ST_READY_BIT = 7;
    localparam int unsigned ST_ERASE_BIT = 5;
    localparam int unsigned ST_PROG_BIT  = 4;
    localparam logic [7:0]  PROT_OPEN_BYTE = 8'h40;
endpackage

// File: rtl/fls_busy_timer.sv
// Busy window timer: a start pulse keeps `active` high for CYCLES cycles.
// `done` marks the final busy cycle, whose closing edge commits the operation.
// Assumes the caller only raises start while idle and CYCLES >= 1.
module fls_busy_timer #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load the window length on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);
    assign done   = (cnt_q == CW'(1));

    // R3: a new operation never starts on top of a running one
    a_r3_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);
    // R3: the window closes right after its last cycle
    a_r3_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active);
    // R3: a start always opens a busy window
    a_r3_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);
endmodule

// File: rtl/fls_lock_bank.sv
// One active-low protection bit per block (0 = protected). A bit is cleared
// only by a protect request and set only by an erase of its block. The bypass
// input opens every block without touching the stored bits.
module fls_lock_bank #(
    parameter int unsigned NUM_BLOCKS = 4,
    localparam int unsigned BLK_W = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_en,
    input  logic [BLK_W-1:0]      clr_idx,
    input  logic [NUM_BLOCKS-1:0] set_mask,
    input  logic                  bypass,
    output logic [NUM_BLOCKS-1:0] lock_q,
    output logic [NUM_BLOCKS-1:0] open_mask
);
    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        logic bit_r;

        // Erase sets the bit; a protect request for this block clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_r <= 1'b1;
            else if (set_mask[i])
                bit_r <= 1'b1;
            else if (clr_en && (clr_idx == BLK_W'(i)))
                bit_r <= 1'b0;
        end

        assign lock_q[i]    = bit_r;
        assign open_mask[i] = bit_r | bypass;

        // R5: an erase leaves the block's bit at 1
        a_r5_erase_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
            set_mask[i] |=> lock_q[i]);
        // R6: without an erase a cleared bit stays cleared
        a_r6_no_cmd_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_mask[i] && !lock_q[i]) |=> !lock_q[i]);
    end
endmodule

// File: rtl/fls_array.sv
// Register model of the flash array. Erase forces a whole block to 0xFF;
// program ANDs new data into one byte. Assumes BLOCK_BYTES is a power of two.
module fls_array #(
    parameter int unsigned NUM_BLOCKS  = 4,
    parameter int unsigned BLOCK_BYTES = 16,
    localparam int unsigned DEPTH = NUM_BLOCKS * BLOCK_BYTES,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         rd_addr,
    output logic [7:0]            rd_byte,
    input  logic                  prog_en,
    input  logic [AW-1:0]         prog_addr,
    input  logic [7:0]            prog_data,
    input  logic [NUM_BLOCKS-1:0] erase_mask
);
    logic [7:0] cells [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_cell
        logic [7:0] cell_r;

        // Erase wins over program; program can only clear bits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_r <= 8'hFF;
            else if (erase_mask[j / BLOCK_BYTES])
                cell_r <= 8'hFF;
            else if (prog_en && (prog_addr == AW'(j)))
                cell_r <= cell_r & prog_data;
        end

        assign cells[j] = cell_r;

        // R4: outside an erase no bit of a cell goes from 0 to 1
        a_r4_and_only: assert property (@(posedge clk) disable iff (!rst_n)
            !erase_mask[j / BLOCK_BYTES] |=> ((cell_r & ~$past(cell_r)) == 8'h00));
    end

    assign rd_byte = cells[rd_addr];
endmodule

// File: rtl/flash_lock_seq.sv
// Command decoder and status sequencer in front of the flash array model.
// It accepts one command per idle cycle, runs long commands through the busy
// timer, enforces the per-block protection (unless bypassed) at completion, and
// selects array, status or protection data onto the read port.
// Assumes NUM_BLOCKS >= 2 and both NUM_BLOCKS and BLOCK_BYTES are powers of two.
module flash_lock_seq
    import fls_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS  = 4,
    parameter int unsigned BLOCK_BYTES = 16,
    parameter int unsigned BUSY_CYCLES = 4,
    localparam int unsigned DEPTH = NUM_BLOCKS * BLOCK_BYTES,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned BW    = $clog2(BLOCK_BYTES),
    localparam int unsigned BLK_W = $clog2(NUM_BLOCKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    cmd_data,
    input  logic          lock_bypass,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          ready,
    output logic          erase_fail,
    output logic          prog_fail
);
    fls_op_e   op_in, op_q;
    fls_mode_e mode_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          perr_q, eerr_q, prot_cap_q;

    logic accept, long_op, start, busy_act, busy_done;
    logic prog_en, prot_clr, perr_set, eerr_set;
    logic [NUM_BLOCKS-1:0] erase_mask, lock_q, open_mask;
    logic [BLK_W-1:0] blk;
    logic [7:0] arr_byte, status_byte;

    assign op_in  = fls_op_e'(cmd_op);
    assign accept = cmd_valid && !busy_act;
    assign blk    = addr_q[AW-1:BW];

    // Classify commands that need the busy window.
    always_comb begin
        case (op_in)
            OP_PROGRAM, OP_ERASE_BLK, OP_ERASE_ALL, OP_PROTECT, OP_RD_PROT: long_op = 1'b1;
            default:                                                        long_op = 1'b0;
        endcase
    end
    assign start = accept && long_op;

    fls_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .active (busy_act),
        .done   (busy_done)
    );

    // Decide the effect of the pending command on its completion edge.
    always_comb begin
        prog_en    = 1'b0;
        prot_clr   = 1'b0;
        perr_set   = 1'b0;
        eerr_set   = 1'b0;
        erase_mask = '0;
        if (busy_done) begin
            case (op_q)
                OP_PROGRAM: begin
                    prog_en  = open_mask[blk];
                    perr_set = !open_mask[blk];
                end
                OP_ERASE_BLK: begin
                    if (open_mask[blk])
                        erase_mask = {{(NUM_BLOCKS-1){1'b0}}, 1'b1} << blk;
                    eerr_set = !open_mask[blk];
                end
                OP_ERASE_ALL: erase_mask = open_mask;
                OP_PROTECT:   prot_clr   = 1'b1;
                default:      ;
            endcase
        end
    end

    fls_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_locks (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en    (prot_clr),
        .clr_idx   (blk),
        .set_mask  (erase_mask),
        .bypass    (lock_bypass),
        .lock_q    (lock_q),
        .open_mask (open_mask)
    );

    fls_array #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (rd_addr),
        .rd_byte    (arr_byte),
        .prog_en    (prog_en),
        .prog_addr  (addr_q),
        .prog_data  (data_q),
        .erase_mask (erase_mask)
    );

    // Read mode, sticky failure flags, pending command and protection capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_ARRAY;
            perr_q     <= 1'b0;
            eerr_q     <= 1'b0;
            op_q       <= OP_RD_ARRAY;
            addr_q     <= '0;
            data_q     <= '0;
            prot_cap_q <= 1'b0;
        end else begin
            if (accept) begin
                case (op_in)
                    OP_RD_ARRAY:  mode_q <= MODE_ARRAY;
                    OP_RD_STATUS: mode_q <= MODE_STATUS;
                    OP_CLR_STAT: begin
                        perr_q <= 1'b0;
                        eerr_q <= 1'b0;
                    end
                    OP_RD_PROT:   mode_q <= MODE_PROT;
                    default:      mode_q <= MODE_STATUS;
                endcase
            end
            if (start) begin
                op_q   <= op_in;
                addr_q <= cmd_addr;
                data_q <= cmd_data;
            end
            if (perr_set) perr_q <= 1'b1;
            if (eerr_set) eerr_q <= 1'b1;
            if (busy_done && op_q == OP_RD_PROT)
                prot_cap_q <= lock_q[blk];
        end
    end

    // Assemble the status byte and steer the read port.
    always_comb begin
        status_byte = '0;
        status_byte[ST_READY_BIT] = ready;
        status_byte[ST_ERASE_BIT] = eerr_q;
        status_byte[ST_PROG_BIT]  = perr_q;
        case (mode_q)
            MODE_STATUS: rd_data = rd_addr[0] ? arr_byte : status_byte;
            MODE_PROT:   rd_data = prot_cap_q ? PROT_OPEN_BYTE : 8'h00;
            default:     rd_data = arr_byte;
        endcase
    end

    assign ready      = !busy_act;
    assign erase_fail = eerr_q;
    assign prog_fail  = perr_q;

    // R2: the read mode cannot change while a command is running
    a_r2_mode_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(mode_q));
    // R11: a program failure persists until clear status is taken
    a_r11_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_fail && !(accept && op_in == OP_CLR_STAT)) |=> prog_fail);
    // R11: an erase failure persists until clear status is taken
    a_r11_eerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_fail && !(accept && op_in == OP_CLR_STAT)) |=> erase_fail);
    // R7: a refused program reports its failure
    a_r7_refused_prog_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_done && op_q == OP_PROGRAM && !open_mask[blk]) |=> prog_fail);
endmodule

// File: tb/sim_flash_lock_seq.sv
// Bench: behavioural reference model compared every cycle, plus directed reads.
module sim_flash_lock_seq;
    localparam int NB = 4, BB = 16, BUSY = 4, DEPTH = NB * BB;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, lock_bypass = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [5:0] cmd_addr = 6'd0, rd_addr = 6'd0;
    logic [7:0] cmd_data = 8'd0;
    logic [7:0] rd_data;
    logic ready, erase_fail, prog_fail;

    int tests = 0, fails = 0;
    bit armed = 1'b0, finished = 1'b0;

    always #4 clk = ~clk;

    flash_lock_seq #(.NUM_BLOCKS(NB), .BLOCK_BYTES(BB), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .lock_bypass(lock_bypass),
        .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready),
        .erase_fail(erase_fail), .prog_fail(prog_fail));

    // Reference model state
    int m_mem [DEPTH];
    bit m_lk [NB];
    int m_mode, m_cnt, m_op, m_addr, m_data;
    bit m_perr, m_eerr, m_cap;

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic m_erase(input int b);
        for (int k = 0; k < BB; k++) m_mem[b*BB + k] = 8'hFF;
        m_lk[b] = 1'b1;
    endtask

    task automatic m_commit();
        int b;
        bit open;
        b = m_addr / BB;
        open = m_lk[b] || lock_bypass;
        case (m_op)
            3: if (open) m_mem[m_addr] = m_mem[m_addr] & m_data; else m_perr = 1'b1;
            4: if (open) m_erase(b); else m_eerr = 1'b1;
            5: for (int q = 0; q < NB; q++) if (m_lk[q] || lock_bypass) m_erase(q);
            6: m_lk[b] = 1'b0;
            7: m_cap = m_lk[b];
            default: ;
        endcase
    endtask

    function automatic int m_read(input int a);
        int st;
        st = (m_cnt == 0 ? 8'h80 : 0) | (m_eerr ? 8'h20 : 0) | (m_perr ? 8'h10 : 0);
        case (m_mode)
            1: return (a % 2 == 0) ? st : m_mem[a];
            2: return m_cap ? 8'h40 : 8'h00;
            default: return m_mem[a];
        endcase
    endfunction

    // Model steps on the same edges as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) m_mem[k] = 8'hFF;
            for (int k = 0; k < NB; k++) m_lk[k] = 1'b1;
            m_mode = 0; m_cnt = 0; m_perr = 0; m_eerr = 0; m_cap = 0;
            m_op = 0; m_addr = 0; m_data = 0;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) m_commit();
        end else if (cmd_valid) begin
            case (int'(cmd_op))
                0: m_mode = 0;
                1: m_mode = 1;
                2: begin m_perr = 0; m_eerr = 0; end
                default: begin
                    m_mode = (cmd_op == 3'd7) ? 2 : 1;
                    m_op = int'(cmd_op); m_addr = int'(cmd_addr); m_data = int'(cmd_data);
                    m_cnt = BUSY;
                end
            endcase
        end
    end

    // Mid-cycle comparison against the model
    always @(negedge clk) begin
        if (armed) begin
            chk("R3 ready", int'(ready), (m_cnt == 0) ? 1 : 0);
            chk("R11 prog flag", int'(prog_fail), int'(m_perr));
            chk("R11 erase flag", int'(erase_fail), int'(m_eerr));
            chk("R9 read port", int'(rd_data), m_read(int'(rd_addr)));
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            cmd_valid = 1'b0;
            rd_addr = rd_addr + 6'd1;
        end
    endtask

    task automatic issue(input int op, input int a, input int d);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = 6'(a); cmd_data = 8'(d);
    endtask

    task automatic run(input int op, input int a, input int d);
        issue(op, a, d);
        idle(BUSY + 1);
    endtask

    task automatic peek(input int a, input int exp, input string tag);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        rd_addr = 6'(a);
        @(negedge clk);
        chk(tag, int'(rd_data), exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        armed = 1'b1;
        @(negedge clk);
        chk("R1 erased array", int'(rd_data), 8'hFF);
        chk("R1 ready", int'(ready), 1);
        chk("R1 flags", int'({erase_fail, prog_fail}), 0);
        run(7, 0, 0);
        peek(0, 8'h40, "R1 unprotected after reset");

        // R4: AND programming
        run(3, 5, 8'hF0);
        run(3, 5, 8'h3C);
        run(0, 0, 0);
        peek(5, 8'h30, "R4 AND result");
        peek(4, 8'hFF, "R4 neighbour untouched");

        // R9: status mode even/odd
        run(3, 5, 8'hFF);
        peek(4, 8'h80, "R9 even reads status");
        peek(5, 8'h30, "R9 odd reads array");

        // R3: busy length
        begin
            int low = 0;
            issue(3, 6, 8'hFF);
            @(posedge clk); #1 cmd_valid = 1'b0;
            repeat (BUSY + 3) begin
                @(negedge clk);
                if (!ready) low++;
            end
            chk("R3 busy cycles", low, BUSY);
        end

        // R2: command while busy ignored
        issue(3, 8, 8'h00);
        issue(3, 9, 8'h00);
        idle(BUSY + 1);
        run(0, 0, 0);
        peek(9, 8'hFF, "R2 busy command ignored");
        peek(8, 8'h00, "R2 accepted command");

        // R6/R10: protect block 1, read protection
        run(6, 16, 0);
        run(7, 16, 0);
        peek(0, 8'h00, "R10 protected reads 00");
        peek(33, 8'h00, "R10 any address");
        run(7, 0, 0);
        peek(0, 8'h40, "R10 open reads 40");

        // R7: refused program / erase
        run(3, 17, 8'h00);
        chk("R7 program refused flag", int'(prog_fail), 1);
        run(4, 16, 0);
        chk("R7 erase refused flag", int'(erase_fail), 1);
        run(0, 0, 0);
        peek(17, 8'hFF, "R7 array unchanged");
        chk("R11 flags persist", int'({erase_fail, prog_fail}), 3);

        // R11: clear status keeps the mode
        run(1, 0, 0);
        run(2, 0, 0);
        peek(2, 8'h80, "R11 clear keeps status mode");
        chk("R11 flags cleared", int'({erase_fail, prog_fail}), 0);

        // R12: back to array mode
        run(0, 0, 0);
        peek(8, 8'h00, "R12 array mode even address");

        // R8: bypass then re-enable
        lock_bypass = 1'b1;
        run(3, 18, 8'h11);
        chk("R8 bypass program ok", int'(prog_fail), 0);
        run(7, 16, 0);
        peek(0, 8'h00, "R8 stored bit kept");
        lock_bypass = 1'b0;
        run(3, 19, 8'h00);
        chk("R8 re-enabled refuses", int'(prog_fail), 1);
        run(2, 0, 0);
        run(0, 0, 0);
        peek(18, 8'h11, "R8 bypass program landed");

        // R5: erase-all skips protected block
        run(5, 0, 0);
        chk("R7 erase-all no flag", int'(erase_fail), 0);
        run(0, 0, 0);
        peek(5, 8'hFF, "R5 erase-all block0");
        peek(8, 8'hFF, "R5 erase-all block0 b");
        peek(18, 8'h11, "R7 protected block kept");

        // R5: bypassed erase of protected block restores its bit
        lock_bypass = 1'b1;
        run(4, 16, 0);
        lock_bypass = 1'b0;
        run(7, 16, 0);
        peek(0, 8'h40, "R5 erase sets protection bit");
        run(0, 0, 0);
        peek(18, 8'hFF, "R5 block erased");

        // R6: protect works under bypass too
        lock_bypass = 1'b1;
        run(6, 32, 0);
        lock_bypass = 1'b0;
        run(7, 32, 0);
        peek(0, 8'h00, "R6 protect under bypass");

        idle(4);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule